// File: doc/BRIEF.md
# Software and RMA Flash Operation Arbiter

This block sits in front of a single flash protocol controller and decides who may issue commands to it: a software command port or a hardware wipe request used when a part is returned for analysis (RMA). Software issues read, program or erase commands. An erase covers either one page or a whole bank. The block forwards each valid software command to the flash side and holds it until the flash side signals done. An unknown command code is refused at once. It never reaches the flash, and it raises a recoverable alert.

An RMA request never cuts off a software command already in flight. The arbiter waits for that command to finish and then runs a wipe of its own. The wipe erases every page of the data partition and then every page of the isolated information partition, one page at a time, in ascending order. After the last page the arbiter enters a terminal state and pulses an acknowledge. It stays in that state until reset. While it is there, every software request completes at once with an access error and issues no flash command.

Top module: `flash_op_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `fl_req_o`, `sw_done_o`, `sw_err_o`, `alert_o` and `rma_ack_o` are all low.
- R2: A software request with a valid command (00 read, 01 program, 10 erase) seen in the idle state drives `fl_req_o` high from the next cycle. The command, partition and page are copied to the flash side and held until `fl_done_i`.
- R3: The bank-erase flag reaches `fl_bank_erase_o` only with command 10 (erase). For read and program it is driven low.
- R4: While a software command is in flight, `sw_done_o` is high with `sw_err_o` low in exactly the cycle where `fl_done_i` is high. `fl_req_o` is low in the following cycle if no RMA is pending.
- R5: Command code 11 in the idle state raises `sw_done_o`, `sw_err_o` and `alert_o` in the same cycle. `fl_req_o` stays low in that cycle and in the next one.
- R6: An RMA request that arrives while a software command is in flight leaves that command on the flash side until its `fl_done_i`. The wipe starts in the next cycle.
- R7: The wipe issues page erases (command 10, bank-erase flag low). It covers data partition (0) pages 0 to NUM_DATA_PAGES-1, then information partition (1) pages 0 to NUM_INFO_PAGES-1, in ascending order. It moves to the next page only on `fl_done_i`.
- R8: `rma_ack_o` is high for exactly one cycle, the first cycle after the `fl_done_i` of the last wiped page.
- R9: After the wipe, `fl_req_o` stays low until reset. Every software request gets `sw_done_o` and `sw_err_o` high in the same cycle, and `alert_o` stays low.
- R10: When an RMA request and a software request are both present in the idle state, the RMA wins. The software request is not answered until the terminal state, where it is refused as in R9.
- R11: While `fl_req_o` is high and `fl_done_i` is low, the command, partition and page on the flash side do not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req_i | input | 1 | Software request, held until `sw_done_o` |
| sw_op_i | input | 2 | Software command: 00 read, 01 program, 10 erase, 11 unknown |
| sw_bank_i | input | 1 | Erase whole bank instead of one page |
| sw_part_i | input | 1 | Target partition: 0 data, 1 information |
| sw_page_i | input | PAGE_W | Target page |
| sw_done_o | output | 1 | Software command completed |
| sw_err_o | output | 1 | Software command refused |
| alert_o | output | 1 | Recoverable alert on an unknown command |
| rma_req_i | input | 1 | RMA wipe request, held until `rma_ack_o` |
| rma_ack_o | output | 1 | Wipe finished, one-cycle pulse |
| fl_req_o | output | 1 | Command valid toward the flash controller |
| fl_op_o | output | 2 | Command code toward the flash controller |
| fl_bank_o | output | 1 | Bank-erase flag toward the flash controller |
| fl_part_o | output | 1 | Partition toward the flash controller |
| fl_page_o | output | PAGE_W | Page toward the flash controller |
| fl_done_i | input | 1 | Flash controller finished the current command |

## Verification
The assertions rely on three things from the environment. The software side holds its request and its command fields steady until `sw_done_o`. The RMA request stays high until `rma_ack_o`. The flash side raises `fl_done_i` only while `fl_req_o` is high. Without these, the stability check on the flash-side fields (R11) would not hold for software commands, since those fields are copied straight from the inputs. The bench drives all inputs at the falling edge and changes a software command only after its done has been seen. It answers the flash side with a random delay of zero to three cycles, and only while a command is pending.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_BAD   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SW_BUSY,
    ST_RMA_WAIT,
    ST_RMA_WIPE,
    ST_RMA_DONE
  } arb_st_e;

  localparam logic PART_DATA = 1'b0;
  localparam logic PART_INFO = 1'b1;

endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_arb_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       bank_i,
  output logic       valid_o,
  output logic       bank_o
);

  always_comb begin
    valid_o = (op_i != OP_BAD);
    bank_o  = (op_i == OP_ERASE) && bank_i;
  end

endmodule

// File: rtl/flash_wipe_seq.sv
module flash_wipe_seq
  import flash_arb_pkg::*;
#(
  parameter int NUM_DATA_PAGES = 8,
  parameter int NUM_INFO_PAGES = 4,
  parameter int PAGE_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic              part_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              last_o
);

  localparam logic [PAGE_W-1:0] DATA_LAST = PAGE_W'(NUM_DATA_PAGES - 1);
  localparam logic [PAGE_W-1:0] INFO_LAST = PAGE_W'(NUM_INFO_PAGES - 1);

  logic              part_q, part_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              part_end;

  always_comb begin
    part_end = (part_q == PART_DATA) ? (page_q == DATA_LAST) : (page_q == INFO_LAST);
    last_o   = (part_q == PART_INFO) && part_end;
    part_d   = part_q;
    page_d   = page_q;
    if (step_i && !last_o) begin
      if (part_end) begin
        part_d = PART_INFO;
        page_d = '0;
      end else begin
        page_d = page_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= PART_DATA;
      page_q <= '0;
    end else if (step_i) begin
      part_q <= part_d;
      page_q <= page_d;
    end
  end

  assign part_o = part_q;
  assign page_o = page_q;

  // R7: the page pointer stays inside the page count of the current partition
  p_page_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (part_q == PART_DATA) ? (page_q <= DATA_LAST) : (page_q <= INFO_LAST));

  // R7: the pointer never returns from the information partition to the data partition
  p_part_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    part_q == PART_INFO |=> part_q == PART_INFO);

endmodule

// File: rtl/flash_op_arbiter.sv
module flash_op_arbiter
  import flash_arb_pkg::*;
#(
  parameter int NUM_DATA_PAGES = 8,
  parameter int NUM_INFO_PAGES = 4,
  localparam int MAX_PAGES = (NUM_DATA_PAGES > NUM_INFO_PAGES) ? NUM_DATA_PAGES : NUM_INFO_PAGES,
  localparam int PAGE_W    = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req_i,
  input  logic [1:0]        sw_op_i,
  input  logic              sw_bank_i,
  input  logic              sw_part_i,
  input  logic [PAGE_W-1:0] sw_page_i,
  output logic              sw_done_o,
  output logic              sw_err_o,
  output logic              alert_o,
  input  logic              rma_req_i,
  output logic              rma_ack_o,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic              fl_bank_o,
  output logic              fl_part_o,
  output logic [PAGE_W-1:0] fl_page_o,
  input  logic              fl_done_i
);

  arb_st_e           state_q, state_d;
  logic              ack_q, ack_d;
  logic              op_valid, op_bank;
  logic              wipe_step, wipe_part, wipe_last;
  logic [PAGE_W-1:0] wipe_page;

  flash_op_decode u_decode (
    .op_i   (sw_op_i),
    .bank_i (sw_bank_i),
    .valid_o(op_valid),
    .bank_o (op_bank)
  );

  assign wipe_step = (state_q == ST_RMA_WIPE) && fl_done_i;

  flash_wipe_seq #(
    .NUM_DATA_PAGES(NUM_DATA_PAGES),
    .NUM_INFO_PAGES(NUM_INFO_PAGES),
    .PAGE_W        (PAGE_W)
  ) u_wipe (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(wipe_step),
    .part_o(wipe_part),
    .page_o(wipe_page),
    .last_o(wipe_last)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rma_req_i)                 state_d = ST_RMA_WIPE;
        else if (sw_req_i && op_valid) state_d = ST_SW_BUSY;
      end
      ST_SW_BUSY: begin
        if (fl_done_i)      state_d = rma_req_i ? ST_RMA_WIPE : ST_IDLE;
        else if (rma_req_i) state_d = ST_RMA_WAIT;
      end
      ST_RMA_WAIT: if (fl_done_i)              state_d = ST_RMA_WIPE;
      ST_RMA_WIPE: if (fl_done_i && wipe_last) state_d = ST_RMA_DONE;
      ST_RMA_DONE: state_d = ST_RMA_DONE;
      default:     state_d = ST_IDLE;
    endcase
    ack_d = (state_q == ST_RMA_WIPE) && (state_d == ST_RMA_DONE);
  end

  // outputs
  always_comb begin
    sw_done_o = 1'b0;
    sw_err_o  = 1'b0;
    alert_o   = 1'b0;
    fl_req_o  = 1'b0;
    fl_op_o   = OP_READ;
    fl_bank_o = 1'b0;
    fl_part_o = PART_DATA;
    fl_page_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_req_i && !op_valid && !rma_req_i) begin
          sw_done_o = 1'b1;
          sw_err_o  = 1'b1;
          alert_o   = 1'b1;
        end
      end
      ST_SW_BUSY, ST_RMA_WAIT: begin
        fl_req_o  = 1'b1;
        fl_op_o   = sw_op_i;
        fl_bank_o = op_bank;
        fl_part_o = sw_part_i;
        fl_page_o = sw_page_i;
        sw_done_o = fl_done_i;
      end
      ST_RMA_WIPE: begin
        fl_req_o  = 1'b1;
        fl_op_o   = OP_ERASE;
        fl_part_o = wipe_part;
        fl_page_o = wipe_page;
      end
      ST_RMA_DONE: begin
        sw_done_o = sw_req_i;
        sw_err_o  = sw_req_i;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign rma_ack_o = ack_q;

  // R9: the terminal state never issues a flash command
  p_locked_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RMA_DONE |-> !fl_req_o);

  // R9: the terminal state is left only through reset
  p_locked_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RMA_DONE |=> state_q == ST_RMA_DONE);

  // R8: the acknowledge lasts one cycle
  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rma_ack_o |=> !rma_ack_o);

  // R8: the acknowledge marks the first cycle of the terminal state
  p_ack_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rma_ack_o |-> (state_q == ST_RMA_DONE) && ($past(state_q) == ST_RMA_WIPE));

  // R5: a refused command issues nothing to the flash side
  p_refuse_no_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err_o |-> !fl_req_o);

  // R3: the bank flag only travels with an erase
  p_bank_only_erase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_bank_o |-> fl_req_o && (fl_op_o == OP_ERASE));

  // R4: a clean software completion coincides with the flash done
  p_done_from_flash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done_o && !sw_err_o |-> fl_done_i && fl_req_o);

  // R6: a pending RMA keeps the in-flight software command on the flash side
  p_wait_keeps_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RMA_WAIT && !fl_done_i |=> state_q == ST_RMA_WAIT);

  // R7: wipe commands are page erases
  p_wipe_page_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RMA_WIPE |-> fl_req_o && (fl_op_o == OP_ERASE) && !fl_bank_o);

  // R11: the flash-side command holds steady until done
  p_cmd_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_o && !fl_done_i |=> fl_req_o && $stable(fl_op_o) && $stable(fl_page_o) && $stable(fl_part_o));

endmodule

// File: tb/test_flash_op_arbiter.sv
`timescale 1ns/1ps
module test_flash_op_arbiter;

  localparam int ND = 8;
  localparam int NI = 4;
  localparam int PW = 3;

  logic          clk, rst_n;
  logic          sw_req_i, sw_bank_i, sw_part_i;
  logic [1:0]    sw_op_i;
  logic [PW-1:0] sw_page_i;
  logic          sw_done_o, sw_err_o, alert_o;
  logic          rma_req_i, rma_ack_o;
  logic          fl_req_o, fl_bank_o, fl_part_o, fl_done_i;
  logic [1:0]    fl_op_o;
  logic [PW-1:0] fl_page_o;

  int checks = 0;
  int fails  = 0;

  flash_op_arbiter #(.NUM_DATA_PAGES(ND), .NUM_INFO_PAGES(NI)) i_flash_op_arbiter (
    .clk(clk), .rst_n(rst_n),
    .sw_req_i(sw_req_i), .sw_op_i(sw_op_i), .sw_bank_i(sw_bank_i),
    .sw_part_i(sw_part_i), .sw_page_i(sw_page_i),
    .sw_done_o(sw_done_o), .sw_err_o(sw_err_o), .alert_o(alert_o),
    .rma_req_i(rma_req_i), .rma_ack_o(rma_ack_o),
    .fl_req_o(fl_req_o), .fl_op_o(fl_op_o), .fl_bank_o(fl_bank_o),
    .fl_part_o(fl_part_o), .fl_page_o(fl_page_o), .fl_done_i(fl_done_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_bank(input logic [1:0] op, input logic bank);
    return (op == 2'b10 && bank) ? 1 : 0;
  endfunction

  function automatic int exp_wipe_part(input int idx);
    return (idx < ND) ? 0 : 1;
  endfunction

  function automatic int exp_wipe_page(input int idx);
    return (idx < ND) ? idx : idx - ND;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; sw_req_i = 1'b0; sw_op_i = '0; sw_bank_i = 1'b0;
    sw_part_i = 1'b0; sw_page_i = '0; rma_req_i = 1'b0; fl_done_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 fl_req in reset", int'(fl_req_o), 0);
    check("R1 ack in reset", int'(rma_ack_o), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 fl_req after reset", int'(fl_req_o), 0);
    check("R1 done/err/alert after reset", int'({sw_done_o, sw_err_o, alert_o}), 0);
    check("R1 ack after reset", int'(rma_ack_o), 0);
  endtask

  // one software command from idle, flash answers after lat cycles
  task automatic sw_cmd(input logic [1:0] op, input logic bank, input logic part,
                        input logic [PW-1:0] page, input int lat);
    @(negedge clk);
    sw_req_i = 1'b1; sw_op_i = op; sw_bank_i = bank; sw_part_i = part; sw_page_i = page;
    #1;
    if (op == 2'b11) begin
      check("R5 refuse done/err/alert", int'({sw_done_o, sw_err_o, alert_o}), 7);
      check("R5 no flash req", int'(fl_req_o), 0);
      @(negedge clk);
      sw_req_i = 1'b0; #1;
      check("R5 no flash req next cycle", int'(fl_req_o), 0);
      return;
    end
    check("R2 no done on accept", int'(sw_done_o), 0);
    @(negedge clk); #1;
    check("R2 fl_req", int'(fl_req_o), 1);
    check("R2 fields", int'({fl_op_o, fl_part_o, fl_page_o}), int'({op, part, page}));
    check("R3 bank flag", int'(fl_bank_o), exp_bank(op, bank));
    for (int i = 0; i < lat; i++) begin
      check("R4 no early done", int'(sw_done_o), 0);
      @(negedge clk); #1;
      check("R11 held", int'({fl_req_o, fl_op_o, fl_page_o}), int'({1'b1, op, page}));
    end
    fl_done_i = 1'b1; #1;
    check("R4 done/err", int'({sw_done_o, sw_err_o}), 2);
    @(negedge clk);
    fl_done_i = 1'b0; sw_req_i = 1'b0; #1;
    check("R4 fl_req low after done", int'(fl_req_o), 0);
  endtask

  // called at a falling edge in the first wipe cycle, before #1
  task automatic run_wipe();
    for (int idx = 0; idx < ND + NI; idx++) begin
      int lat;
      lat = int'($urandom_range(0, 3));
      #1;
      check("R7 wipe cmd", int'({fl_req_o, fl_op_o, fl_bank_o}), int'({1'b1, 2'b10, 1'b0}));
      check("R7 wipe partition", int'(fl_part_o), exp_wipe_part(idx));
      check("R7 wipe page", int'(fl_page_o), exp_wipe_page(idx));
      for (int s = 0; s < lat; s++) begin
        @(negedge clk); #1;
        check("R7 waits for done", int'(fl_page_o), exp_wipe_page(idx));
        check("R8 no early ack", int'(rma_ack_o), 0);
      end
      fl_done_i = 1'b1;
      @(negedge clk);
      fl_done_i = 1'b0;
    end
    #1;
    check("R8 ack pulse", int'(rma_ack_o), 1);
    check("R9 no flash req", int'(fl_req_o), 0);
    rma_req_i = 1'b0;
    @(negedge clk); #1;
    check("R8 ack single cycle", int'(rma_ack_o), 0);
  endtask

  task automatic check_locked();
    for (int k = 0; k < 6; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      @(negedge clk);
      sw_req_i = 1'b1; sw_op_i = op; sw_bank_i = 1'b1; #1;
      check("R9 refused", int'({sw_done_o, sw_err_o}), 3);
      check("R9 no alert", int'(alert_o), 0);
      check("R9 no flash req", int'(fl_req_o), 0);
      @(negedge clk);
      sw_req_i = 1'b0; #1;
      check("R9 still locked", int'(fl_req_o), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // directed corner cases
    sw_cmd(2'b10, 1'b1, 1'b0, 3'd5, 0);   // bank erase
    sw_cmd(2'b01, 1'b1, 1'b1, 3'd2, 2);   // program with bank flag set
    sw_cmd(2'b11, 1'b0, 1'b0, 3'd0, 0);   // unknown command
    sw_cmd(2'b00, 1'b0, 1'b1, 3'd7, 3);   // read

    // random software commands
    for (int n = 0; n < 60; n++) begin
      sw_cmd(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             PW'($urandom_range(0, 7)), int'($urandom_range(0, 3)));
    end

    // RMA arrives while a software erase is in flight
    @(negedge clk);
    sw_req_i = 1'b1; sw_op_i = 2'b10; sw_bank_i = 1'b0; sw_part_i = 1'b1; sw_page_i = 3'd6;
    @(negedge clk);
    rma_req_i = 1'b1;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); #1;
      check("R6 sw command kept", int'({fl_req_o, fl_part_o, fl_page_o}), int'({1'b1, 1'b1, 3'd6}));
      check("R6 no done yet", int'(sw_done_o), 0);
    end
    fl_done_i = 1'b1; #1;
    check("R6 sw completes clean", int'({sw_done_o, sw_err_o}), 2);
    @(negedge clk);
    fl_done_i = 1'b0; sw_req_i = 1'b0;
    run_wipe();
    check_locked();

    // simultaneous RMA and software request in idle
    do_reset();
    @(negedge clk);
    sw_req_i = 1'b1; sw_op_i = 2'b11; rma_req_i = 1'b1; #1;
    check("R10 sw not answered", int'({sw_done_o, alert_o}), 0);
    @(negedge clk);
    run_wipe();
    @(negedge clk); #1;
    check("R10 held request refused", int'({sw_done_o, sw_err_o}), 3);
    sw_req_i = 1'b0;
    check_locked();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule